// File: doc/BRIEF.md
# Request-Paced Burst Transfer Engine

This block moves data for one DMA channel in bursts paced by peripheral request lines. It keeps a small control word for every request line: the access width, the number of operations per burst, and the transfer direction. Once the channel is started on a line, each rising edge of that line's request starts one burst. A burst is a series of load/store operations. Each operation reads one item and then writes it back, using a simple memory-side request/acknowledge bus. One side of the transfer is a fixed device address. The other side is a memory pointer that advances by the access width after each operation.

The block also tracks which request lines are allocated. It holds a 32-bit in-use mask in which lines 0 and 31 are permanently reserved. Line 0 has a second role: a channel started on line 0 runs free, starting bursts back to back without waiting for any request. A request edge that arrives while a burst is running is remembered and serviced as soon as that burst ends. A one-cycle pulse marks the end of every burst.

Top module: `dreq_burst_engine`

## Requirements
- R1: After reset `line_mask` reads 0x8000_0001, `mem_req` and `burst_done` are low, and bits 0 and 31 of the mask stay set at all times.
- R2: An allocation of a free line below 32 sets only that bit of `line_mask` and pulses `alloc_ok` for one cycle, one cycle after the request.
- R3: An allocation of line 32 or above, of a reserved line (0 or 31), or of a line already in use pulses `alloc_err` and leaves `line_mask` unchanged.
- R4: A release clears only the named bit. A release of line 0 or line 31 has no effect.
- R5: A configuration width of 1, 2, 4 or 8 bytes is stored as size code 0, 1, 2 or 3, and that code appears on `mem_size` during the line's bursts. Any other width pulses `cfg_err` and leaves the stored control word unchanged.
- R6: A burst performs `cfg_nops`+1 operations. Each operation is one read followed by one write. A request holds its address and its direction stable until it is acknowledged.
- R7: With the direction bit `cfg_to_dev` set, each read goes to the memory pointer and each write goes to the device address. With the bit clear, the two are swapped.
- R8: The device address stays constant. The memory pointer advances by the access size after every operation and continues from that value in the next burst.
- R9: A channel started on line 0 issues bursts back to back with no request input. After `ch_stop`, no new burst begins.
- R10: A rising edge on the channel's line during a burst is held pending. The next burst's first read request appears in the cycle right after that burst's done pulse. Edges on other lines have no effect.
- R11: `burst_done` is high for exactly one cycle, in the cycle after the last write of a burst is acknowledged.
- R12: The write data of each operation equals the read data returned for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate request line |
| alloc_line | input | 6 | Line number to allocate |
| alloc_ok | output | 1 | Allocation granted (pulse) |
| alloc_err | output | 1 | Allocation refused (pulse) |
| rel_req | input | 1 | Release request line |
| rel_line | input | 5 | Line number to release |
| line_mask | output | 32 | In-use mask |
| cfg_we | input | 1 | Write a line's control word |
| cfg_line | input | 5 | Line being configured |
| cfg_bytes | input | 4 | Access width in bytes |
| cfg_nops | input | 4 | Operations per burst minus one |
| cfg_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| cfg_err | output | 1 | Width rejected (pulse) |
| ch_start | input | 1 | Start channel (ignored during a burst) |
| ch_stop | input | 1 | Stop channel after current burst |
| ch_line | input | 5 | Line that paces the channel, 0 = free running |
| ch_dev_addr | input | 32 | Fixed device address |
| ch_mem_addr | input | 32 | Initial memory pointer |
| dreq | input | 32 | Peripheral request lines |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | 32 | Bus address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 64 | Read data, valid with acknowledge |
| burst_done | output | 1 | End-of-burst pulse |

## Verification
If the burst counter or the latched control word were wrong, the error would show within the same burst: a missing or extra read/write pair, or a wrong `mem_size`, before `burst_done`. If the memory pointer were wrong, the addresses would be off from the second operation onward, or from the first operation of the following burst. If the pending flag were lost or duplicated, the cycle after `burst_done` would show no request, or an unexpected extra burst would follow. If the mask were wrong, it would show on `line_mask` one cycle after the allocation or release.

// File: rtl/dreq_burst_engine.sv
module dreq_burst_engine #(
  parameter int NLINES = 32,
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int NOPS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [$clog2(NLINES):0]   alloc_line,
  output logic              alloc_ok,
  output logic              alloc_err,
  input  logic              rel_req,
  input  logic [$clog2(NLINES)-1:0] rel_line,
  output logic [NLINES-1:0] line_mask,
  input  logic              cfg_we,
  input  logic [$clog2(NLINES)-1:0] cfg_line,
  input  logic [3:0]        cfg_bytes,
  input  logic [NOPS_W-1:0] cfg_nops,
  input  logic              cfg_to_dev,
  output logic              cfg_err,
  input  logic              ch_start,
  input  logic              ch_stop,
  input  logic [$clog2(NLINES)-1:0] ch_line,
  input  logic [AW-1:0]     ch_dev_addr,
  input  logic [AW-1:0]     ch_mem_addr,
  input  logic [NLINES-1:0] dreq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              burst_done
);
  localparam int LW = $clog2(NLINES);
  localparam logic [NLINES-1:0] RSV = {1'b1, {(NLINES-2){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  // line allocation
  logic [LW-1:0]     a_idx;
  logic              a_good;
  logic [NLINES-1:0] set_v, clr_v;

  assign a_idx  = alloc_line[LW-1:0];
  assign a_good = alloc_req && (int'(alloc_line) < NLINES) && !line_mask[a_idx];
  assign set_v  = a_good  ? (NLINES'(1) << a_idx)    : '0;
  assign clr_v  = rel_req ? (NLINES'(1) << rel_line) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_mask <= RSV;
      alloc_ok  <= 1'b0;
      alloc_err <= 1'b0;
    end else begin
      line_mask <= ((line_mask | set_v) & ~clr_v) | RSV;
      alloc_ok  <= a_good;
      alloc_err <= alloc_req && !a_good;
    end
  end

  // per-line control words
  logic [1:0]        opc_r [NLINES];
  logic [NOPS_W-1:0] nops_r[NLINES];
  logic              dir_r [NLINES];
  logic [1:0]        w_opc;
  logic              w_ok;

  always_comb begin
    w_ok  = 1'b1;
    w_opc = 2'd0;
    case (cfg_bytes)
      4'd1:    w_opc = 2'd0;
      4'd2:    w_opc = 2'd1;
      4'd4:    w_opc = 2'd2;
      4'd8:    w_opc = 2'd3;
      default: w_ok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      for (int i = 0; i < NLINES; i++) begin
        opc_r[i]  <= '0;
        nops_r[i] <= '0;
        dir_r[i]  <= 1'b0;
      end
    end else begin
      cfg_err <= cfg_we && !w_ok;
      if (cfg_we && w_ok) begin
        opc_r[cfg_line]  <= w_opc;
        nops_r[cfg_line] <= cfg_nops;
        dir_r[cfg_line]  <= cfg_to_dev;
      end
    end
  end

  // burst engine
  st_t               st;
  logic              run, pend, cur_dir;
  logic [LW-1:0]     line_q;
  logic [AW-1:0]     dev_q, ptr_q;
  logic [NOPS_W-1:0] cnt;
  logic [1:0]        cur_opc;
  logic [DW-1:0]     buf_q;
  logic [NLINES-1:0] dreq_q;
  logic              rise, fire, take_start;

  assign rise       = run && dreq[line_q] && !dreq_q[line_q];
  assign fire       = (st == S_IDLE) && run && ((line_q == '0) || rise || pend);
  assign take_start = ch_start && (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      run        <= 1'b0;
      pend       <= 1'b0;
      line_q     <= '0;
      dev_q      <= '0;
      ptr_q      <= '0;
      cnt        <= '0;
      cur_opc    <= '0;
      cur_dir    <= 1'b0;
      buf_q      <= '0;
      dreq_q     <= '0;
      burst_done <= 1'b0;
    end else begin
      dreq_q     <= dreq;
      burst_done <= 1'b0;
      if (ch_stop) begin
        run  <= 1'b0;
        pend <= 1'b0;
      end else if (take_start) begin
        run    <= 1'b1;
        pend   <= 1'b0;
        line_q <= ch_line;
        dev_q  <= ch_dev_addr;
        ptr_q  <= ch_mem_addr;
      end else if (fire) begin
        pend <= 1'b0;
      end else if (rise) begin
        pend <= 1'b1;
      end
      case (st)
        S_IDLE: if (fire && !ch_stop && !take_start) begin
          cnt     <= nops_r[line_q];
          cur_opc <= opc_r[line_q];
          cur_dir <= dir_r[line_q];
          st      <= S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st    <= S_WR;
        end
        S_WR: if (mem_ack) begin
          ptr_q <= ptr_q + (AW'(1) << cur_opc);
          if (cnt == '0) begin
            st         <= S_IDLE;
            burst_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
            st  <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_size  = cur_opc;
  assign mem_wdata = buf_q;
  assign mem_addr  = ((st == S_RD) == cur_dir) ? ptr_q : dev_q;

  AST_RSV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    line_mask[0] && line_mask[NLINES-1]); // R1
  AST_ALLOC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({alloc_ok, alloc_err})); // R2
  AST_ALLOC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err && !$past(rel_req) |-> $stable(line_mask)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(mem_req && mem_we && mem_ack)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done); // R11
endmodule

// File: tb/sim_dreq_burst_engine.sv
`timescale 1ns/1ps
module sim_dreq_burst_engine;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic alloc_req = 0, rel_req = 0, cfg_we = 0, cfg_to_dev = 0;
  logic ch_start = 0, ch_stop = 0, mem_ack = 0;
  logic [5:0] alloc_line = 0;
  logic [4:0] rel_line = 0, cfg_line = 0, ch_line = 0;
  logic [3:0] cfg_bytes = 0, cfg_nops = 0;
  logic [31:0] ch_dev_addr = 0, ch_mem_addr = 0, dreq = 0, line_mask, mem_addr;
  logic alloc_ok, alloc_err, cfg_err, mem_req, mem_we, burst_done;
  logic [1:0] mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  assign mem_rdata = {mem_addr, ~mem_addr};

  dreq_burst_engine u0 (.*);

  int n_chk = 0, n_fail = 0, done_cnt = 0, nlog = 0;
  logic        lg_we  [64];
  logic [31:0] lg_addr[64];
  logic [1:0]  lg_size[64];
  logic [63:0] lg_wd  [64];

  always @(negedge clk) begin
    if (burst_done) done_cnt++;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (nlog < 64) begin
        lg_we[nlog] = mem_we; lg_addr[nlog] = mem_addr;
        lg_size[nlog] = mem_size; lg_wd[nlog] = mem_wdata;
      end
      nlog++;
      mem_ack = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic alloc(input int ln, input bit exp_ok, input logic [31:0] exp_mask, input string req);
    @(negedge clk); alloc_req = 1; alloc_line = 6'(ln);
    @(negedge clk); alloc_req = 0;
    chk(alloc_ok == exp_ok && alloc_err == !exp_ok, req, {alloc_ok, alloc_err}, {exp_ok, !exp_ok});
    chk(line_mask == exp_mask, req, line_mask, exp_mask);
  endtask

  task automatic release_line(input int ln, input logic [31:0] exp_mask, input string req);
    @(negedge clk); rel_req = 1; rel_line = 5'(ln);
    @(negedge clk); rel_req = 0;
    chk(line_mask == exp_mask, req, line_mask, exp_mask);
  endtask

  task automatic cfg(input int ln, input int b, input int n, input bit d);
    @(negedge clk); cfg_we = 1; cfg_line = 5'(ln); cfg_bytes = 4'(b); cfg_nops = 4'(n); cfg_to_dev = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic start_ch(input int ln, input logic [31:0] dev, mem);
    @(negedge clk); ch_start = 1; ch_line = 5'(ln); ch_dev_addr = dev; ch_mem_addr = mem;
    @(negedge clk); ch_start = 0;
  endtask

  task automatic pulse_dreq(input int ln);
    @(negedge clk); dreq[ln] = 1;
    @(negedge clk); @(negedge clk); dreq[ln] = 0;
  endtask

  task automatic wait_done(input int target);
    for (int t = 0; t < 400 && done_cnt < target; t++) @(negedge clk);
    chk(done_cnt >= target, "R11 done seen", 64'(done_cnt), 64'(target));
  endtask

  task automatic check_ops(input int first, input int nops, input int b, input bit d,
                           input logic [31:0] dev, input logic [31:0] mem);
    logic [31:0] src, dst, p;
    logic [1:0] oc;
    oc = (b == 1) ? 2'd0 : (b == 2) ? 2'd1 : (b == 4) ? 2'd2 : 2'd3;
    for (int k = 0; k <= nops; k++) begin
      p = mem + 32'(k * b);
      src = d ? p : dev;
      dst = d ? dev : p;
      chk(lg_we[first+2*k] == 0 && lg_addr[first+2*k] == src, "R7 R8 read addr", lg_addr[first+2*k], src);
      chk(lg_we[first+2*k+1] == 1 && lg_addr[first+2*k+1] == dst, "R7 R8 write addr", lg_addr[first+2*k+1], dst);
      chk(lg_size[first+2*k] == oc, "R5 size code", lg_size[first+2*k], oc);
      chk(lg_wd[first+2*k+1] == {src, ~src}, "R12 write data", lg_wd[first+2*k+1], {src, ~src});
    end
  endtask

  localparam int VEC[4][3] = '{'{1, 0, 0}, '{2, 3, 1}, '{4, 2, 0}, '{8, 1, 1}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(line_mask == 32'h8000_0001, "R1 reset mask", line_mask, 32'h8000_0001);
    chk(!mem_req && !burst_done, "R1 reset idle", {mem_req, burst_done}, 0);

    alloc(5, 1, 32'h8000_0021, "R2 alloc 5");
    alloc(5, 0, 32'h8000_0021, "R3 alloc in use");
    alloc(32, 0, 32'h8000_0021, "R3 alloc 32");
    alloc(0, 0, 32'h8000_0021, "R3 alloc 0");
    alloc(31, 0, 32'h8000_0021, "R3 alloc 31");
    alloc(7, 1, 32'h8000_00A1, "R2 alloc 7");
    release_line(5, 32'h8000_0081, "R4 release 5");
    release_line(0, 32'h8000_0081, "R4 release 0");
    release_line(31, 32'h8000_0081, "R4 release 31");

    for (int i = 0; i < 4; i++) begin
      logic [31:0] dv, mm;
      int d0;
      dv = 32'h4000_0000 + 32'(i * 32'h100);
      mm = 32'h1000_0000 + 32'(i * 32'h1000);
      cfg(5, VEC[i][0], VEC[i][1], VEC[i][2] != 0);
      chk(!cfg_err, "R5 good width accepted", cfg_err, 0);
      start_ch(5, dv, mm);
      nlog = 0; d0 = done_cnt;
      pulse_dreq(5);
      wait_done(d0 + 1);
      repeat (4) @(negedge clk);
      chk(nlog == 2 * (VEC[i][1] + 1), "R6 op count", 64'(nlog), 64'(2 * (VEC[i][1] + 1)));
      check_ops(0, VEC[i][1], VEC[i][0], VEC[i][2] != 0, dv, mm);
    end

    // R5 rejected width keeps the 8-byte word from the last vector
    @(negedge clk); cfg_we = 1; cfg_line = 5; cfg_bytes = 3; cfg_nops = 0; cfg_to_dev = 0;
    @(negedge clk); cfg_we = 0;
    chk(cfg_err, "R5 bad width error", cfg_err, 1);
    // R10 pending edge and carried pointer (R8)
    begin
      int d0, at_done;
      start_ch(5, 32'h4000_0000, 32'h2000_0000);
      nlog = 0; d0 = done_cnt;
      pulse_dreq(5);
      repeat (2) @(negedge clk);
      pulse_dreq(5);
      at_done = 0;
      for (int t = 0; t < 200 && !burst_done; t++) @(negedge clk);
      chk(burst_done, "R11 first done", burst_done, 1);
      @(negedge clk);
      chk(mem_req && !burst_done, "R10 pending serviced next cycle", {mem_req, burst_done}, 2'b10);
      wait_done(d0 + 2);
      repeat (10) @(negedge clk);
      chk(nlog == 8, "R10 exactly two bursts", 64'(nlog), 8);
      check_ops(0, 1, 8, 1, 32'h4000_0000, 32'h2000_0000);
      check_ops(4, 1, 8, 1, 32'h4000_0000, 32'h2000_0010);
      // other line ignored
      nlog = 0; d0 = done_cnt;
      pulse_dreq(7);
      repeat (10) @(negedge clk);
      chk(nlog == 0 && done_cnt == d0, "R10 other line ignored", 64'(nlog), 0);
    end

    // R9 free running on line 0
    begin
      int d0;
      cfg(0, 2, 0, 1);
      nlog = 0; d0 = done_cnt;
      start_ch(0, 32'h4000_0800, 32'h3000_0000);
      wait_done(d0 + 3);
      chk(done_cnt >= d0 + 3, "R9 free-run bursts without request", 64'(done_cnt), 64'(d0 + 3));
      check_ops(0, 0, 2, 1, 32'h4000_0800, 32'h3000_0000);
      check_ops(2, 0, 2, 1, 32'h4000_0800, 32'h3000_0002);
      @(negedge clk); ch_stop = 1;
      @(negedge clk); ch_stop = 0;
      repeat (8) @(negedge clk);
      d0 = done_cnt; nlog = 0;
      repeat (12) @(negedge clk);
      chk(nlog == 0 && done_cnt == d0 && !mem_req, "R9 stop halts", 64'(nlog), 0);
    end
    finish_run();
  end
endmodule